// File: doc/BRIEF.md
# Two-register I2C port expander slave

This block is an I2C target with a fixed-format register set. It keeps two 6-bit output-port registers, A and B, and passes a 6-bit input-port value back to the bus. Every master transfer is one of two kinds. A write transfer carries data bytes that each name their target register in the top two bits. A read transfer returns A, then B, then the input port, and keeps going round that cycle for as long as the master acknowledges. There is no pointer register.

SCL and SDA are sampled with the system clock. Each line passes through a two-flop synchronizer and a persistence filter before any edge is detected. The block only pulls SDA low through an open-drain enable and never drives SCL. A strap input selects one of two slave addresses.

A committed write starts a busy timer that stands in for the slow update of non-volatile storage. While the timer runs, further write bytes are refused. Reads keep working during that time.

Top module: `i2c_dual_port_slave`

## Requirements
- R1: A change on SCL or SDA that lasts fewer than FILT_CYCLES system clocks after synchronization is ignored. In particular, a short low pulse on SDA while SCL is high causes neither a START nor a STOP.
- R2: The address byte carries the slave address in bits [7:1] and the direction in bit 0 (1 = read). The slave address is 7'b1001110 when addr_sel_i is 1 and 7'b0110111 when addr_sel_i is 0. On a match the block acknowledges by pulling SDA low during the ninth clock.
- R3: Any other address, including the general call 7'b0000000, is not acknowledged. Bytes that follow it are neither acknowledged nor stored until the next START.
- R4: In a write data byte, bits [7:6] = 00 load bits [5:0] into register A and 01 load them into register B. The byte is acknowledged and the register appears on port_a_o / port_b_o.
- R5: A read returns {2'b00,A}, then {2'b00,B}, then {2'b00,port_in_i}, each MSB first. If the master keeps acknowledging, the sequence wraps back to A. A master NACK ends the transfer, and every new read starts again at A.
- R6: A write data byte with bits [7:6] = 10 or 11 is acknowledged, leaves both registers unchanged and does not start the busy timer.
- R7: After an accepted write, busy_o is high for exactly BUSY_CYCLES clocks. A write data byte that arrives while busy_o is high is not acknowledged and changes nothing. Reads stay available and return the committed values.
- R8: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START may follow a read byte without a STOP in between and begin a write to the same slave.
- R9: sda_oe_o is asserted only for an acknowledge or a 0 data bit, and it changes only while SCL is low. The block has no SCL output.
- R10: During and after reset, A and B are 0, busy_o is 0 and sda_oe_o is 0.
- R11: Reads change neither register contents nor the busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock as seen on the pad |
| sda_i | input | 1 | Bus data as seen on the pad |
| sda_oe_o | output | 1 | 1 = pull SDA low (open drain) |
| addr_sel_i | input | 1 | Address strap |
| port_in_i | input | 6 | Input-port value returned as the third read byte |
| port_a_o | output | 6 | Register A |
| port_b_o | output | 6 | Register B |
| busy_o | output | 1 | Non-volatile update in progress |

## Verification
A bus edge reaches the controller about FILT_CYCLES+3 clocks after it appears on a pin: two synchronizer flops, the filter run and the edge register. Acknowledges and read bits therefore appear on sda_oe_o about seven clocks after the SCL falling edge. The bench master holds each quarter of a bit period for ten clocks and samples SDA in the middle of the SCL-high phase, so every response is settled by the time it is read. Register outputs are checked only after STOP, once busy_o has gone low. The busy window is measured as an exact run length of busy_o.

// File: rtl/i2cdp_pkg.sv
`timescale 1ns/1ps
package i2cdp_pkg;
  localparam int unsigned PORT_W = 6;
  localparam logic [6:0] SLV_ADDR_SEL1 = 7'b1001110;
  localparam logic [6:0] SLV_ADDR_SEL0 = 7'b0110111;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } ctl_state_e;
endpackage

// File: rtl/i2cdp_line_filter.sv
`timescale 1ns/1ps
module i2cdp_line_filter #(
  parameter int unsigned FILT_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_CYCLES + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
        out_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = out_q;

  // output only follows a level the synchronizer actually held
  p_filter_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q != $past(out_q)) |-> ($past(sync_q[1]) == out_q));
endmodule

// File: rtl/i2cdp_port_regs.sv
`timescale 1ns/1ps
module i2cdp_port_regs
  import i2cdp_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_byte_i,
  output logic              busy_o,
  output logic [PORT_W-1:0] port_a_o,
  output logic [PORT_W-1:0] port_b_o
);
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 2);

  logic [CW-1:0]     cnt_q;
  logic [PORT_W-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (wr_en_i && cnt_q == '0 && !wr_byte_i[7]) begin
      if (wr_byte_i[6]) b_q <= wr_byte_i[PORT_W-1:0];
      else              a_q <= wr_byte_i[PORT_W-1:0];
      cnt_q <= CW'(BUSY_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = (cnt_q != '0);
  assign port_a_o = a_q;
  assign port_b_o = b_q;

  p_hold_while_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(a_q) && $stable(b_q)));
  p_reserved_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_byte_i[7]) |=> ($stable(a_q) && $stable(b_q)));
  p_busy_starts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !busy_o && !wr_byte_i[7]) |=> (busy_o || BUSY_CYCLES == 0));
endmodule

// File: rtl/i2cdp_ctl.sv
`timescale 1ns/1ps
module i2cdp_ctl
  import i2cdp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  input  logic              busy_i,
  input  logic [PORT_W-1:0] rd_a_i,
  input  logic [PORT_W-1:0] rd_b_i,
  input  logic [PORT_W-1:0] rd_in_i,
  output logic              wr_en_o,
  output logic [7:0]        wr_byte_o,
  output logic              sda_oe_o
);
  ctl_state_e state_q;
  logic       scl_q, sda_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q;
  logic       rw_q, oe_q, mack_q, wr_en_q;
  logic [1:0] idx_q, next_idx;
  logic [7:0] rd_first, rd_next;
  logic [6:0] my_addr;
  logic       scl_rise, scl_fall, start_ev, stop_ev;

  function automatic logic [7:0] rd_byte(input logic [1:0] idx,
                                         input logic [PORT_W-1:0] a,
                                         input logic [PORT_W-1:0] b,
                                         input logic [PORT_W-1:0] pin);
    case (idx)
      2'd0:    rd_byte = {2'b00, a};
      2'd1:    rd_byte = {2'b00, b};
      default: rd_byte = {2'b00, pin};
    endcase
  endfunction

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
  assign my_addr  = addr_sel_i ? SLV_ADDR_SEL1 : SLV_ADDR_SEL0;
  assign next_idx = (idx_q == 2'd2) ? 2'd0 : idx_q + 2'd1;
  assign rd_first = rd_byte(2'd0, rd_a_i, rd_b_i, rd_in_i);
  assign rd_next  = rd_byte(next_idx, rd_a_i, rd_b_i, rd_in_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      cnt_q   <= '0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
      wr_en_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      scl_q   <= scl_i;
      sda_q   <= sda_i;
      wr_en_q <= 1'b0;
      if (start_ev) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_ev) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              if (state_q == ST_ADDR) begin
                if (sh_q[7:1] == my_addr) begin
                  oe_q    <= 1'b1;
                  rw_q    <= sh_q[0];
                  idx_q   <= '0;
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                // refuse data while the storage update is pending
                oe_q    <= ~busy_i;
                wr_en_q <= ~busy_i;
                state_q <= ST_WACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            cnt_q <= '0;
            if (rw_q) begin
              sh_q    <= rd_first;
              oe_q    <= ~rd_first[7];
              state_q <= ST_RDATA;
            end else begin
              oe_q    <= 1'b0;
              state_q <= ST_WDATA;
            end
          end
          ST_WACK: if (scl_fall) begin
            oe_q    <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_WDATA;
          end
          ST_RDATA: if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_q    <= 1'b0;
              state_q <= ST_RACK;
            end else begin
              sh_q  <= {sh_q[6:0], 1'b0};
              oe_q  <= ~sh_q[6];
              cnt_q <= cnt_q + 4'd1;
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_i;
            end else if (scl_fall) begin
              if (mack_q) begin
                idx_q   <= next_idx;
                sh_q    <= rd_next;
                oe_q    <= ~rd_next[7];
                cnt_q   <= '0;
                state_q <= ST_RDATA;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_byte_o = sh_q;
  assign sda_oe_o  = oe_q;

  p_idle_released_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);
  p_pull_on_low_scl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_q);
  p_no_write_when_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_q) |-> !$past(busy_i));
  p_read_index_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q != 2'd3);
endmodule

// File: rtl/i2c_dual_port_slave.sv
`timescale 1ns/1ps
module i2c_dual_port_slave
  import i2cdp_pkg::*;
#(
  parameter int unsigned FILT_CYCLES = 3,
  parameter int unsigned BUSY_CYCLES = 2000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              addr_sel_i,
  input  logic [PORT_W-1:0] port_in_i,
  output logic [PORT_W-1:0] port_a_o,
  output logic [PORT_W-1:0] port_b_o,
  output logic              busy_o
);
  logic       scl_f, sda_f, wr_en, busy;
  logic [7:0] wr_byte;
  logic [PORT_W-1:0] reg_a, reg_b;

  i2cdp_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_scl_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i), .line_o(scl_f));
  i2cdp_line_filter #(.FILT_CYCLES(FILT_CYCLES)) u_sda_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i), .line_o(sda_f));

  i2cdp_ctl u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_f), .sda_i(sda_f),
    .addr_sel_i(addr_sel_i), .busy_i(busy),
    .rd_a_i(reg_a), .rd_b_i(reg_b), .rd_in_i(port_in_i),
    .wr_en_o(wr_en), .wr_byte_o(wr_byte), .sda_oe_o(sda_oe_o));

  i2cdp_port_regs #(.BUSY_CYCLES(BUSY_CYCLES)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_byte_i(wr_byte),
    .busy_o(busy), .port_a_o(reg_a), .port_b_o(reg_b));

  assign port_a_o = reg_a;
  assign port_b_o = reg_b;
  assign busy_o   = busy;

  p_reset_quiet_r10: assert property (@(posedge clk_i)
    !rst_ni |=> (!sda_oe_o && !busy_o && port_a_o == '0 && port_b_o == '0));
endmodule

// File: tb/i2c_dual_port_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_dual_port_slave_tb_top;
  localparam int FILT = 3;
  localparam int BUSY = 2000;
  localparam int Q    = 10;
  localparam logic [6:0] AD1 = 7'b1001110;
  localparam logic [6:0] AD0 = 7'b0110111;

  typedef struct packed {
    logic       asel;
    logic [7:0] wbyte;
    logic       ack;
    logic [5:0] exp_a;
    logic [5:0] exp_b;
  } vec_t;

  localparam vec_t VEC [0:5] = '{
    '{1'b1, 8'h15, 1'b1, 6'h15, 6'h00},
    '{1'b0, 8'h6A, 1'b1, 6'h15, 6'h2A},
    '{1'b1, 8'hBF, 1'b1, 6'h15, 6'h2A},
    '{1'b0, 8'hC0, 1'b1, 6'h15, 6'h2A},
    '{1'b1, 8'h3F, 1'b1, 6'h3F, 6'h2A},
    '{1'b0, 8'h40, 1'b1, 6'h3F, 6'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, asel = 1'b1;
  logic [5:0] pin = 6'h2D;
  logic sda_oe, busy;
  logic [5:0] pa, pb;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  int run_len = 0, last_len = 0, oe_hi_chg = 0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  i2c_dual_port_slave #(.FILT_CYCLES(FILT), .BUSY_CYCLES(BUSY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_sel_i(asel), .port_in_i(pin),
    .port_a_o(pa), .port_b_o(pb), .busy_o(busy));

  always @(negedge clk) begin
    if (busy) run_len <= run_len + 1;
    else begin
      if (run_len != 0) last_len <= run_len;
      run_len <= 0;
    end
    if (sda_oe != oe_prev && scl_m) oe_hi_chg <= oe_hi_chg + 1;
    oe_prev <= sda_oe;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1;
      if (glitch && b[i]) begin
        wq(Q/2); sda_m = 1'b0; wq(2); sda_m = 1'b1; wq(2*Q - Q/2 - 2);
      end else wq(2*Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    ack = ~sda_line; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = ~mack; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy) wq(1);
    wq(2);
  endtask

  initial begin
    wq(150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    wq(5);
    chk("R10 oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    wq(5);
    chk("R10 A after reset", int'(pa), 0);
    chk("R10 B after reset", int'(pb), 0);
    chk("R10 busy after reset", int'(busy), 0);

    foreach (VEC[k]) begin
      asel = VEC[k].asel; wq(4);
      do_start();
      send_byte({VEC[k].asel ? AD1 : AD0, 1'b0}, 1'b0, ack);
      chk("R2 address ack", int'(ack), 1);
      send_byte(VEC[k].wbyte, 1'b0, ack);
      chk("R4 data ack", int'(ack), int'(VEC[k].ack));
      do_stop();
      if (VEC[k].wbyte[7]) chk("R6 reserved select no busy", int'(busy), 0);
      wait_idle();
      chk("R4 port A", int'(pa), int'(VEC[k].exp_a));
      chk("R4 port B", int'(pb), int'(VEC[k].exp_b));
      if (!VEC[k].wbyte[7]) chk("R7 busy length", last_len, BUSY);
    end

    // R3: other strap address and general call
    asel = 1'b1; wq(4);
    do_start(); send_byte({AD0, 1'b0}, 1'b0, ack);
    chk("R3 foreign address nack", int'(ack), 0);
    send_byte(8'h01, 1'b0, ack);
    chk("R3 data after foreign address", int'(ack), 0);
    do_stop(); wq(4);
    chk("R3 A untouched", int'(pa), 6'h3F);
    do_start(); send_byte(8'h00, 1'b0, ack);
    chk("R3 general call nack", int'(ack), 0);
    do_stop(); wq(4);

    // load B for a distinct read pattern
    do_start(); send_byte({AD1, 1'b0}, 1'b0, ack);
    send_byte(8'h59, 1'b0, ack); do_stop(); wait_idle();
    chk("R4 B loaded", int'(pb), 6'h19);

    // R5: read sequence with wrap
    do_start(); send_byte({AD1, 1'b1}, 1'b0, ack);
    chk("R2 read address ack", int'(ack), 1);
    recv_byte(1'b1, rb); chk("R5 first byte A", int'(rb), 8'h3F);
    recv_byte(1'b1, rb); chk("R5 second byte B", int'(rb), 8'h19);
    recv_byte(1'b1, rb); chk("R5 third byte input port", int'(rb), 8'h2D);
    recv_byte(1'b0, rb); chk("R5 wrap to A", int'(rb), 8'h3F);
    do_stop(); wq(4);

    // R11: single-byte read, then a new read restarts at A
    do_start(); send_byte({AD1, 1'b1}, 1'b0, ack);
    recv_byte(1'b0, rb); do_stop();
    chk("R11 early stop byte", int'(rb), 8'h3F);
    do_start(); send_byte({AD1, 1'b1}, 1'b0, ack);
    recv_byte(1'b0, rb); do_stop(); wq(4);
    chk("R5 new read starts at A", int'(rb), 8'h3F);
    chk("R11 A after reads", int'(pa), 6'h3F);
    chk("R11 B after reads", int'(pb), 6'h19);
    chk("R11 busy after reads", int'(busy), 0);

    // R8: repeated START from read into write
    do_start(); send_byte({AD1, 1'b1}, 1'b0, ack);
    recv_byte(1'b0, rb);
    do_start(); send_byte({AD1, 1'b0}, 1'b0, ack);
    chk("R8 address ack after repeated start", int'(ack), 1);
    send_byte(8'h0C, 1'b0, ack); do_stop(); wait_idle();
    chk("R8 write after repeated start", int'(pa), 6'h0C);

    // R7: second byte during busy refused, read still served
    do_start(); send_byte({AD1, 1'b0}, 1'b0, ack);
    send_byte(8'h21, 1'b0, ack);
    chk("R7 first write ack", int'(ack), 1);
    send_byte(8'h47, 1'b0, ack);
    chk("R7 busy write nack", int'(ack), 0);
    do_stop();
    do_start(); send_byte({AD1, 1'b1}, 1'b0, ack);
    recv_byte(1'b0, rb); do_stop();
    chk("R7 read during busy", int'(rb), 8'h21);
    chk("R7 still busy during read", int'(busy), 1);
    wait_idle();
    chk("R7 B unchanged", int'(pb), 6'h19);

    // R1: SDA glitch while SCL high must not break the transfer
    do_start(); send_byte({AD1, 1'b0}, 1'b0, ack);
    send_byte(8'h2B, 1'b1, ack);
    chk("R1 glitched byte ack", int'(ack), 1);
    do_stop(); wait_idle();
    chk("R1 glitched byte stored", int'(pa), 6'h2B);

    chk("R9 oe changes only with SCL low", oe_hi_chg, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule